// File: doc/BRIEF.md
# Arithmetic-Logic Unit with Stored Condition Flags

This block combines a 32-bit arithmetic and logic datapath with a six-bit condition register. Each cycle it takes two operands and an operation code. It returns the result combinationally and also forms six condition bits: carry, signed overflow, sign, zero, nibble (auxiliary) carry and low-byte parity. When the update strobe is high, those six bits are written into the condition register at the next rising clock edge. The stored carry bit is fed back as the carry or borrow input of the two extended operations, so wide sums and differences can be chained over several cycles.

Use it as the execute stage of a small processor core. The core holds the strobe low on cycles whose result must not disturb the stored condition bits.

Top module: `flag_alu`

## Requirements
- R1: `op_sel` encoding is 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 OR, 6 XOR, 7 reserved. Add returns `a_in + b_in` modulo 2^32, and carry is set when the unsigned sum exceeds 2^32-1.
- R2: Add-with-carry returns `a_in + b_in + C` modulo 2^32, where C is the stored carry flag. Carry is set when that unsigned sum exceeds 2^32-1.
- R3: Subtract returns `a_in - b_in` modulo 2^32. Carry acts as a borrow and is set exactly when `a_in < b_in` as unsigned values.
- R4: Subtract-with-borrow returns `a_in - b_in - C`, with C the stored carry flag. Carry is set when `a_in < b_in + C` as unsigned values.
- R5: For the four arithmetic codes, overflow is set exactly when the true signed (two's complement) result lies outside -2^31 to 2^31-1.
- R6: Sign equals bit 31 of the result. Zero is set exactly when the result is all zeros.
- R7: The auxiliary flag reports a carry out of bit 3 for add codes, or a borrow into bit 3 for subtract codes, using the low four bits of the operands and the same carry or borrow input.
- R8: Parity is set when bits 7..0 of the result contain an even number of ones.
- R9: AND, OR and XOR give the bitwise result, clear carry, overflow and auxiliary, and update sign, zero and parity from the result.
- R10: The flag outputs take the newly formed flags at a rising edge with `flag_we` high, and hold their value at every edge with `flag_we` low.
- R11: While `rst_n` is low, all six flag outputs are 0.
- R12: Code 7 gives a zero result and treats the flags like a logic operation: zero and parity set, all others clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the condition register |
| a_in | input | 32 | First operand |
| b_in | input | 32 | Second operand (subtrahend for subtract codes) |
| op_sel | input | 3 | Operation code |
| flag_we | input | 1 | Write strobe for the condition register |
| result | output | 32 | Combinational result |
| f_carry | output | 1 | Stored carry / borrow flag |
| f_ovf | output | 1 | Stored signed overflow flag |
| f_sign | output | 1 | Stored sign flag |
| f_zero | output | 1 | Stored zero flag |
| f_aux | output | 1 | Stored nibble carry / borrow flag |
| f_par | output | 1 | Stored low-byte even parity flag |

## Verification
The assertions assume that operands, operation code and strobe are stable and known at each rising edge, and that `rst_n` starts low. The bench meets this by changing inputs only on the falling edge and by holding reset over the first few cycles.

Random stimulus takes all eight operation codes, full 32-bit operands and a random strobe from a fixed seed. Because the strobe is random, chained add-with-carry and subtract-with-borrow run with both carry values. Directed cases cover the edges that random data rarely hits: wrap to zero, the largest positive value plus one, zero minus one, equal operands, and a low nibble that carries or borrows alone.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_ADC = 3'd1,
      OP_SUB = 3'd2,
      OP_SBB = 3'd3,
      OP_AND = 3'd4,
      OP_OR  = 3'd5,
      OP_XOR = 3'd6,
      OP_RSV = 3'd7
   } alu_op_e;

   typedef struct packed {
      logic cf;
      logic of;
      logic sf;
      logic zf;
      logic af;
      logic pf;
   } cond_flags_t;

endpackage

// File: rtl/flag_alu_arith.sv
module flag_alu_arith #(
   parameter int WIDTH = 32,
   parameter int NIB   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             is_sub,
   input  logic             use_cin,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cf,
   output logic             of,
   output logic             af
);
   localparam int MSB = WIDTH - 1;

   if (NIB < 1 || NIB >= WIDTH) begin : g_bad_nib
      $error("flag_alu_arith: NIB must lie in 1..WIDTH-1");
   end

   logic [WIDTH-1:0] b_eff;
   logic             c0;
   logic [WIDTH:0]   ext;
   logic [NIB:0]     low;

   always_comb begin
      b_eff = is_sub ? ~b : b;
      c0    = use_cin ? (cin ^ is_sub) : is_sub;
      ext   = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c0};
      low   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c0};
      sum   = ext[MSB:0];
      cf    = ext[WIDTH] ^ is_sub;
      af    = low[NIB] ^ is_sub;
      of    = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
   end

   // plain subtract: borrow iff a below b as unsigned
   assert_sub_borrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_sub && !use_cin) |-> (cf == (a < b)));

   // plain add: carry iff the widened sum exceeds the range
   assert_add_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_sub && !use_cin) |-> (cf == (({1'b0, a} + {1'b0, b}) > {1'b0, {WIDTH{1'b1}}})));

   // adding values of opposite sign can never overflow
   assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_sub && (a[MSB] != b[MSB])) |-> !of);

endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
   import flag_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  alu_op_e          op,
   output logic [WIDTH-1:0] res
);
   always_comb begin
      unique case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/flag_alu_condreg.sv
module flag_alu_condreg
   import flag_alu_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  cond_flags_t flags_d,
   output cond_flags_t flags_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flags_q <= '0;
      else if (we) flags_q <= flags_d;
   end

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> (flags_q == $past(flags_q)));

   assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (flags_q == $past(flags_d)));

   assert_reset_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (flags_q == '0));
endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import flag_alu_pkg::*;
#(
   parameter int WIDTH    = 32,
   parameter int NIB      = 4,
   parameter int PAR_BITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic [2:0]       op_sel,
   input  logic             flag_we,
   output logic [WIDTH-1:0] result,
   output logic             f_carry,
   output logic             f_ovf,
   output logic             f_sign,
   output logic             f_zero,
   output logic             f_aux,
   output logic             f_par
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 8) begin : g_bad_width
      $error("flag_alu: WIDTH must be at least 8");
   end
   if (PAR_BITS < 1 || PAR_BITS > WIDTH) begin : g_bad_par
      $error("flag_alu: PAR_BITS must lie in 1..WIDTH");
   end

   alu_op_e          op;
   logic             is_arith, is_sub, use_cin;
   logic [WIDTH-1:0] arith_res, logic_res;
   logic             a_cf, a_of, a_af;
   logic             par_even;
   cond_flags_t      flags_d, flags_q;

   always_comb begin
      op       = alu_op_e'(op_sel);
      is_arith = (op == OP_ADD) || (op == OP_ADC) || (op == OP_SUB) || (op == OP_SBB);
      is_sub   = (op == OP_SUB) || (op == OP_SBB);
      use_cin  = (op == OP_ADC) || (op == OP_SBB);
   end

   flag_alu_arith #(.WIDTH(WIDTH), .NIB(NIB)) u_arith (
      .clk     (clk),
      .rst_n   (rst_n),
      .a       (a_in),
      .b       (b_in),
      .is_sub  (is_sub),
      .use_cin (use_cin),
      .cin     (flags_q.cf),
      .sum     (arith_res),
      .cf      (a_cf),
      .of      (a_of),
      .af      (a_af)
   );

   flag_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a   (a_in),
      .b   (b_in),
      .op  (op),
      .res (logic_res)
   );

   // parity over the low PAR_BITS bits; full-width variant skips the slice
   if (PAR_BITS == WIDTH) begin : g_par_full
      assign par_even = ~^result;
   end else begin : g_par_low
      assign par_even = ~^result[PAR_BITS-1:0];
   end

   always_comb begin
      result     = is_arith ? arith_res : logic_res;
      flags_d.cf = is_arith & a_cf;
      flags_d.of = is_arith & a_of;
      flags_d.af = is_arith & a_af;
      flags_d.sf = result[MSB];
      flags_d.zf = (result == '0);
      flags_d.pf = par_even;
   end

   flag_alu_condreg u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (flag_we),
      .flags_d (flags_d),
      .flags_q (flags_q)
   );

   assign f_carry = flags_q.cf;
   assign f_ovf   = flags_q.of;
   assign f_sign  = flags_q.sf;
   assign f_zero  = flags_q.zf;
   assign f_aux   = flags_q.af;
   assign f_par   = flags_q.pf;

   // logic and reserved codes never raise the arithmetic-only flags
   assert_logic_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !is_arith |-> (!flags_d.cf && !flags_d.of && !flags_d.af));

   // reserved code returns zero
   assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd7) |-> (result == '0 && flags_d.zf));

   // a zero result must report zero and even parity
   assert_zero_parity_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (result == '0) |-> (flags_d.zf && flags_d.pf && !flags_d.sf));

endmodule

// File: tb/tb_flag_alu.sv
module tb_flag_alu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] a_in = '0, b_in = '0;
   logic [2:0]  op_sel = '0;
   logic        flag_we = 1'b0;
   logic [31:0] result;
   logic        f_carry, f_ovf, f_sign, f_zero, f_aux, f_par;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   logic [5:0] mflags = '0;   // model of stored {cf,of,sf,zf,af,pf}

   flag_alu dut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .op_sel(op_sel),
      .flag_we(flag_we), .result(result), .f_carry(f_carry), .f_ovf(f_ovf),
      .f_sign(f_sign), .f_zero(f_zero), .f_aux(f_aux), .f_par(f_par)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run did not finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   function automatic logic [37:0] ref_model(input logic [31:0] a, input logic [31:0] b,
                                             input int op, input logic c);
      logic [32:0] full;
      logic [31:0] r;
      logic cf, of, af, sf, zf, pf;
      longint sa, sb, sr;
      int ci;
      ci = (op == 1 || op == 3) ? int'(c) : 0;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      cf = 1'b0; of = 1'b0; af = 1'b0; r = '0;
      case (op)
         0, 1: begin
            full = {1'b0, a} + {1'b0, b} + 33'(ci);
            r  = full[31:0];
            cf = full[32];
            sr = sa + sb + longint'(ci);
            of = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            af = (int'(a[3:0]) + int'(b[3:0]) + ci) > 15;
         end
         2, 3: begin
            r  = a - b - 32'(ci);
            cf = (33'(a) < (33'(b) + 33'(ci)));
            sr = sa - sb - longint'(ci);
            of = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            af = int'(a[3:0]) < (int'(b[3:0]) + ci);
         end
         4: r = a & b;
         5: r = a | b;
         6: r = a ^ b;
         default: r = '0;
      endcase
      sf = r[31];
      zf = (r == 32'd0);
      pf = ~^r[7:0];
      return {r, cf, of, sf, zf, af, pf};
   endfunction

   function automatic string op_tag(input int op);
      case (op)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         7: return "R12";
         default: return "R9";
      endcase
   endfunction

   task automatic step(input logic [31:0] a, input logic [31:0] b, input int op, input logic we);
      logic [37:0] exp;
      logic [5:0]  got;
      @(negedge clk);
      a_in = a; b_in = b; op_sel = 3'(op); flag_we = we;
      exp = ref_model(a, b, op, mflags[5]);
      #1;
      checks++;
      if (result !== exp[37:6]) begin
         fails++;
         $display("FAIL %s result op=%0d a=%h b=%h: got %h expected %h",
                  op_tag(op), op, a, b, result, exp[37:6]);
      end
      @(posedge clk);
      #1;
      if (we) mflags = exp[5:0];
      got = {f_carry, f_ovf, f_sign, f_zero, f_aux, f_par};
      checks++;
      if (got !== mflags) begin
         fails++;
         if (we)
            $display("FAIL %s/R5/R6/R7/R8 flags op=%0d a=%h b=%h: got %b expected %b",
                     op_tag(op), op, a, b, got, mflags);
         else
            $display("FAIL R10 flags held op=%0d: got %b expected %b", op, got, mflags);
      end
   endtask

   initial begin
      void'($urandom(32'h1357_2468));
      repeat (3) @(posedge clk);
      #1;
      checks++;   // R11 reset state
      if ({f_carry, f_ovf, f_sign, f_zero, f_aux, f_par} !== 6'b0) begin
         fails++;
         $display("FAIL R11 reset flags: got %b expected 000000",
                  {f_carry, f_ovf, f_sign, f_zero, f_aux, f_par});
      end
      @(negedge clk);
      rst_n = 1'b1;

      step(32'hFFFF_FFFF, 32'h1, 0, 1'b1);       // R1 wrap: carry, zero, aux, parity
      step(32'h7FFF_FFFF, 32'h1, 0, 1'b1);       // R5 positive overflow
      step(32'h8000_0000, 32'h8000_0000, 1, 1'b1); // R2 negative overflow, carry out
      step(32'h0000_0005, 32'h0000_0006, 1, 1'b1); // R2 uses stored carry = 1
      step(32'h0, 32'h1, 2, 1'b1);               // R3 borrow 0-1
      step(32'h1234_5678, 32'h1234_5678, 2, 1'b1); // R3 equal, zero
      step(32'h8000_0000, 32'h1, 2, 1'b1);       // R5 signed subtract overflow
      step(32'h0, 32'h1, 2, 1'b1);               // set borrow
      step(32'h10, 32'h0, 3, 1'b1);              // R4 and R7 nibble borrow with C=1
      step(32'h0000_000F, 32'h1, 0, 1'b1);       // R7 nibble carry only
      step(32'hF0F0_F0F0, 32'hFF00_FF03, 4, 1'b1); // R9 AND
      step(32'h0, 32'h8000_0001, 5, 1'b1);       // R9 OR, odd parity, sign
      step(32'hAAAA_AAAA, 32'hAAAA_AAAA, 6, 1'b1); // R9 XOR zero
      step(32'h1, 32'hFFFF_FFFF, 0, 1'b0);       // R10 strobe low: flags held
      step(32'h0, 32'h1, 2, 1'b0);               // R10 held again
      step(32'hDEAD_BEEF, 32'h1234, 7, 1'b1);    // R12 reserved code
      step(32'h0000_0003, 32'h0, 5, 1'b1);       // R8 two ones: even parity

      for (int i = 0; i < 600; i++) begin
         step($urandom, $urandom, int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule